// File: doc/BRIEF.md
# UART Special Character Detector

This block sits between a UART receiver and its receive FIFO. Every character the receiver delivers is passed on for writing into the FIFO. In parallel it is compared with a programmable match character. The comparison uses only as many low-order bits as the current word length selects, so a 5-bit link never compares stray upper bits.

When detection is switched on, software flow control is off and a character matches, a sticky interrupt flag is raised. The matching character is still stored like any other character; it is not removed from the data stream. The flag stays set until the host pulses a clear input. A new match in the same cycle as the clear wins over the clear.

Outputs are registered, so the FIFO write strobe, the stored character and the flag all reflect the inputs of the previous clock cycle.

Top module: `uart_spchar_detect`

## Requirements
- R1: While reset is high and in the first cycle after it, fifo_wr is 0, fifo_data is 0 and spchar_flag is 0.
- R2: A cycle with rx_valid=1 and fifo_full=0 gives fifo_wr=1 in the next cycle, with fifo_data equal to rx_char.
- R3: No write occurs (fifo_wr stays 0) for a cycle with rx_valid=0 or fifo_full=1.
- R4: wlen_sel encodes the word length: 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. Only bits [N-1:0] of rx_char and match_char take part in the comparison.
- R5: spchar_flag becomes 1 in the cycle after rx_valid=1 if all of these hold: det_en=1, flow_mode=0, and the low N bits of rx_char equal those of match_char.
- R6: rx_char bits at position N and above are zeroed in fifo_data, and differences in those bits on either side do not stop a match.
- R7: With det_en=0 or any bit of flow_mode set, no character raises spchar_flag.
- R8: Once set, spchar_flag holds through idle and non-matching cycles until a cycle with flag_clr=1, after which it reads 0.
- R9: When a setting match and flag_clr=1 occur in the same cycle, spchar_flag is 1 afterwards.
- R10: A match raises spchar_flag even when fifo_full=1 and no write happens.
- R11: A character that raises spchar_flag is also written to the FIFO when it has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | rx_char holds a new received character this cycle |
| rx_char | input | 8 | Received character, LSB in bit 0 |
| wlen_sel | input | 2 | Word length select (0..3 gives 5..8 bits) |
| det_en | input | 1 | Special character detection enable |
| flow_mode | input | 4 | Software flow control mode; detection requires all zero |
| match_char | input | 8 | Programmed special character, bit 0 aligned with the received LSB |
| fifo_full | input | 1 | Receive FIFO cannot accept a write |
| flag_clr | input | 1 | Host clear pulse for the special character flag |
| fifo_wr | output | 1 | Registered FIFO write strobe |
| fifo_data | output | 8 | Registered character for the FIFO, upper bits masked |
| spchar_flag | output | 1 | Sticky special character interrupt flag |

## Verification
The assertions assume that rx_valid is a one-cycle strobe for each character. They also assume that wlen_sel, det_en, flow_mode and match_char are steady while a character is presented. A check that relates fifo_data to the previous cycle's word length relies on that. The stimulus drives every input on the falling clock edge and holds the configuration for the whole cycle in which rx_valid is high. It drops rx_valid before the next character, so each character is seen at exactly one rising edge.

// File: rtl/spchar_pkg.sv
package spchar_pkg;
  localparam int MIN_WORD_BITS = 5;
  typedef enum logic [1:0] {
    WLEN_5 = 2'd0,
    WLEN_6 = 2'd1,
    WLEN_7 = 2'd2,
    WLEN_8 = 2'd3
  } wlen_e;
endpackage

// File: rtl/spchar_cmp.sv
module spchar_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        wlen,
  input  logic [DATA_W-1:0] char_in,
  input  logic [DATA_W-1:0] match_in,
  output logic [DATA_W-1:0] char_masked,
  output logic              hit
);
  import spchar_pkg::*;
  localparam int BASE = DATA_W - 3;

  logic [DATA_W-1:0] mask;

  // one enable per bit position: bit g takes part when below the word length
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (g < BASE + int'(wlen));
  end

  assign char_masked = char_in & mask;
  assign hit         = ((char_in ^ match_in) & mask) == '0;

  always_comb begin
    assert (BASE + 3 >= MIN_WORD_BITS + 3);
  end
endmodule

// File: rtl/spchar_flag.sv
module spchar_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> flag_o); // R9
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o); // R8
endmodule

// File: rtl/uart_spchar_detect.sv
module uart_spchar_detect #(
  parameter int DATA_W = 8,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_char,
  input  logic [1:0]        wlen_sel,
  input  logic              det_en,
  input  logic [MODE_W-1:0] flow_mode,
  input  logic [DATA_W-1:0] match_char,
  input  logic              fifo_full,
  input  logic              flag_clr,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  output logic              spchar_flag
);
  localparam int BASE = DATA_W - 3;

  logic [DATA_W-1:0] char_masked;
  logic              char_hit;
  logic              det_set;

  spchar_cmp #(.DATA_W(DATA_W)) u_cmp (
    .wlen        (wlen_sel),
    .char_in     (rx_char),
    .match_in    (match_char),
    .char_masked (char_masked),
    .hit         (char_hit)
  );

  // detection is independent of FIFO room
  assign det_set = rx_valid && det_en && (flow_mode == '0) && char_hit;

  spchar_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (det_set),
    .clr_i  (flag_clr),
    .flag_o (spchar_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
    end else begin
      fifo_wr <= rx_valid && !fifo_full;
      if (rx_valid && !fifo_full) fifo_data <= char_masked;
    end
  end

  AST_WR_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> $past(rx_valid && !fifo_full)); // R3
  AST_DATA_MASKED: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> ((fifo_data >> (BASE + int'($past(wlen_sel)))) == '0)); // R6
  AST_SET_NEEDS_DETECT: assert property (@(posedge clk) disable iff (rst)
    $rose(spchar_flag) |-> $past(rx_valid && det_en && flow_mode == '0)); // R7
  AST_FULL_STILL_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (det_set && fifo_full) |=> (spchar_flag && !fifo_wr)); // R10
endmodule

// File: tb/uart_spchar_detect_bench.sv
`timescale 1ns/1ps
module uart_spchar_detect_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       rx_valid;
  logic [7:0] rx_char;
  logic [1:0] wlen_sel;
  logic       det_en;
  logic [3:0] flow_mode;
  logic [7:0] match_char;
  logic       fifo_full;
  logic       flag_clr;
  logic       fifo_wr;
  logic [7:0] fifo_data;
  logic       spchar_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_spchar_detect u_uart_spchar_detect (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_char(rx_char),
    .wlen_sel(wlen_sel), .det_en(det_en), .flow_mode(flow_mode),
    .match_char(match_char), .fifo_full(fifo_full), .flag_clr(flag_clr),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .spchar_flag(spchar_flag)
  );

  typedef struct packed {
    logic [1:0] wl;
    logic [7:0] ch;
    logic [7:0] mt;
    logic       en;
    logic [3:0] mode;
    logic       full;
    logic       ewr;
    logic [7:0] edat;
    logic       eflag;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd3, 8'hA5, 8'hA5, 1'b1, 4'h0, 1'b0, 1'b1, 8'hA5, 1'b1}, // R5 R11 8-bit match
    '{2'd3, 8'hA5, 8'hA4, 1'b1, 4'h0, 1'b0, 1'b1, 8'hA5, 1'b0}, // R5 lsb differs
    '{2'd0, 8'hE5, 8'h05, 1'b1, 4'h0, 1'b0, 1'b1, 8'h05, 1'b1}, // R4 R6 5-bit
    '{2'd0, 8'h15, 8'h05, 1'b1, 4'h0, 1'b0, 1'b1, 8'h15, 1'b0}, // R4 bit4 differs
    '{2'd1, 8'h7F, 8'h3F, 1'b1, 4'h0, 1'b0, 1'b1, 8'h3F, 1'b1}, // R4 R6 6-bit
    '{2'd1, 8'h1F, 8'h3F, 1'b1, 4'h0, 1'b0, 1'b1, 8'h1F, 1'b0}, // R4 bit5 differs
    '{2'd2, 8'hFF, 8'h7F, 1'b1, 4'h0, 1'b0, 1'b1, 8'h7F, 1'b1}, // R4 R6 7-bit
    '{2'd2, 8'h40, 8'hC0, 1'b1, 4'h0, 1'b0, 1'b1, 8'h40, 1'b1}, // R6 match side upper bit
    '{2'd3, 8'h11, 8'h11, 1'b0, 4'h0, 1'b0, 1'b1, 8'h11, 1'b0}, // R7 disabled
    '{2'd3, 8'h11, 8'h11, 1'b1, 4'h2, 1'b0, 1'b1, 8'h11, 1'b0}, // R7 flow control on
    '{2'd3, 8'h3C, 8'h3C, 1'b1, 4'h0, 1'b1, 1'b0, 8'h00, 1'b1}, // R10 R3 full
    '{2'd3, 8'h80, 8'h00, 1'b1, 4'h0, 1'b0, 1'b1, 8'h80, 1'b0}  // R2 R4 msb counts
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic present(logic [7:0] ch, logic clr);
    @(negedge clk);
    rx_char  = ch;
    rx_valid = 1'b1;
    flag_clr = clr;
    @(negedge clk);
    rx_valid = 1'b0;
    flag_clr = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rx_valid = 1'b0; rx_char = '0; wlen_sel = 2'd3; det_en = 1'b1;
    flow_mode = '0; match_char = '0; fifo_full = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 wr", {7'b0, fifo_wr}, 8'h00);
    check("R1 data", fifo_data, 8'h00);
    check("R1 flag", {7'b0, spchar_flag}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release flag", {7'b0, spchar_flag}, 8'h00);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      clear_flag();
      @(negedge clk);
      wlen_sel = VEC[i].wl; rx_char = VEC[i].ch; match_char = VEC[i].mt;
      det_en = VEC[i].en; flow_mode = VEC[i].mode; fifo_full = VEC[i].full;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      check("R2/R3 wr", {7'b0, fifo_wr}, {7'b0, VEC[i].ewr});
      if (VEC[i].ewr) check("R2/R6 data", fifo_data, VEC[i].edat);
      check("R5/R7/R10 flag", {7'b0, spchar_flag}, {7'b0, VEC[i].eflag});
      fifo_full = 1'b0;
    end

    // R3: no valid, no write
    @(negedge clk);
    check("R3 idle wr", {7'b0, fifo_wr}, 8'h00);

    // R8: sticky through idle and non-matching characters
    wlen_sel = 2'd3; det_en = 1'b1; flow_mode = '0; match_char = 8'h5A;
    clear_flag();
    present(8'h5A, 1'b0);
    check("R11 write with match", {7'b0, fifo_wr}, 8'h01);
    repeat (4) @(negedge clk);
    present(8'h00, 1'b0);
    check("R8 held", {7'b0, spchar_flag}, 8'h01);
    clear_flag();
    check("R8 cleared", {7'b0, spchar_flag}, 8'h00);

    // R9: match and clear in the same cycle
    present(8'h5A, 1'b0);
    present(8'h5A, 1'b1);
    check("R9 set wins", {7'b0, spchar_flag}, 8'h01);
    // clear with non-matching character clears
    present(8'h01, 1'b1);
    check("R8 clear with miss", {7'b0, spchar_flag}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule